// File: doc/BRIEF.md
# Shift-Subtract Restoring Divider

This block divides an unsigned double-width dividend by a single-width divisor over several clock cycles. A start request loads the dividend into a pair of working registers: a high half, which becomes the partial remainder, and a low half, which supplies dividend bits. Each cycle then produces one quotient bit. On every step the partial remainder and dividend are shifted left by one bit, with the bit that leaves the top of the remainder kept as a ninth-bit carry. The divisor is subtracted only when the widened partial remainder is at least as large as the divisor. After WIDTH steps the quotient and the remainder are both held on the outputs.

Before any step runs, the block compares the dividend's high half with the divisor. If the high half is not smaller, the quotient cannot fit in WIDTH bits, so the request is refused at once and flagged as overflow. A zero divisor always falls into this case. A caller pulses start while the block is idle and waits for the done pulse. It then reads the overflow flag and, when that flag is clear, the quotient and remainder.

Top module: `shift_sub_divider`

## Requirements
- R1: A start accepted while idle, with the dividend's upper WIDTH bits greater than or equal to the divisor, runs no steps. busy_o stays low, and in the next cycle done_o and overflow_o are both 1.
- R2: A divisor of zero always ends in overflow, whatever the dividend.
- R3: A start accepted without overflow raises busy_o in the next cycle. busy_o stays high for exactly WIDTH cycles.
- R4: done_o is 1 for a single cycle, in the cycle right after the last step. busy_o is already low in that cycle.
- R5: After a run without overflow, quotient_o equals floor(dividend / divisor) and remainder_o equals dividend mod divisor. Both hold until the next accepted start.
- R6: After a run without overflow, remainder_o is less than the divisor.
- R7: start_i is ignored while busy_o is high. The run in progress finishes with the operands it loaded.
- R8: overflow_o stays at its value until the next accepted start. While it is 1, quotient_o and remainder_o read zero.
- R9: After reset, busy_o, done_o and overflow_o are 0, and quotient_o and remainder_o are zero.
- R10: The result is correct when the partial remainder needs its carry bit. An example is a divisor with the top bit set and a dividend whose high half is divisor - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a division; taken only while idle |
| dividend_i | input | 2*WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Steps are in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Last request was refused: quotient too wide or divisor zero |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
The bench targets several corner cases:
- A high half exactly equal to the divisor. A design that compared with strict greater-than would start a run and return a truncated quotient.
- Operands that need the shifted-out carry. A design that dropped the carry would skip subtractions and return a wrong quotient and a remainder at or above the divisor.
- A zero divisor. A design that missed this case would report a quotient of all ones instead of overflow.
- A start pulse in the middle of a run. A design that took it would restart with the new operands, or stretch busy beyond WIDTH cycles.

A behavioural model compares busy, done and overflow on every cycle, so an off-by-one step count shows up as an early or late done.

// File: rtl/div_pkg.sv
// Package: shared definitions for the shift-subtract divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package div_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/div_step.sv
// Module: div_step
// One restoring step, purely combinational. It shifts {carry, rem, low} left
// by one bit, compares the (WIDTH+1)-bit partial remainder with the divisor,
// subtracts on success and shifts the new quotient bit into the quotient.
// Assumes: the partial remainder on entry is below the divisor.
module div_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] low_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dsr_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] low_o,
    output logic [WIDTH-1:0] quo_o
);
    localparam int PW = WIDTH + 1;

    logic [PW-1:0] part;
    logic [PW-1:0] diff;
    logic          fits;

    // Build the widened partial remainder; the top bit is the shifted-out carry.
    always_comb begin
        part  = {rem_i, low_i[WIDTH-1]};
        diff  = part - {1'b0, dsr_i};
        fits  = (part >= {1'b0, dsr_i});
        rem_o = fits ? diff[WIDTH-1:0] : part[WIDTH-1:0];
        low_o = {low_i[WIDTH-2:0], 1'b0};
        quo_o = {quo_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequencer for the divider. It takes a start request only while idle,
// refuses it at once when the datapath reports a too-wide quotient, and
// otherwise runs exactly WIDTH steps before pulsing done.
// Assumes: WIDTH >= 2; too_wide_i is valid in the cycle start_i is high.
module div_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic too_wide_i,
    output logic load_o,
    output logic reject_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o,
    output logic overflow_o
);
    import div_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    div_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    // Decode the request handshake for this cycle.
    always_comb begin
        accept   = start_i && (state_q == ST_IDLE);
        load_o   = accept && !too_wide_i;
        reject_o = accept && too_wide_i;
        step_o   = (state_q == ST_RUN);
        busy_o   = (state_q == ST_RUN);
    end

    // State, step counter and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            done_o     <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        state_q    <= ST_RUN;
                        cnt_q      <= '0;
                        overflow_o <= 1'b0;
                    end else if (reject_o) begin
                        done_o     <= 1'b1;
                        overflow_o <= 1'b1;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: a refused request runs no steps and reports overflow next cycle.
    a_r1_no_overflow_steps: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> (done_o && overflow_o && !busy_o));

    // R3: a run starts at step zero.
    a_r3_run_begins: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (busy_o && cnt_q == '0));

    // R3/R4: after the last step, busy drops and done rises.
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == LAST) |=> (done_o && !busy_o));

    // R4: done never overlaps a run.
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: a start during a run does not end it early.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cnt_q != LAST) |=> busy_o);
endmodule

// File: rtl/div_datapath.sv
// Module: div_datapath
// Working registers of the divider: partial remainder, low dividend half,
// quotient and latched divisor. It also forms the up-front width check.
// Assumes: load_i, reject_i and step_i are mutually exclusive.
module div_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0]   divisor_i,
    input  logic               load_i,
    input  logic               reject_i,
    input  logic               step_i,
    input  logic               done_i,
    input  logic               overflow_i,
    output logic               too_wide_o,
    output logic [WIDTH-1:0]   quotient_o,
    output logic [WIDTH-1:0]   remainder_o
);
    logic [WIDTH-1:0] rem_q, low_q, quo_q, dsr_q;
    logic [WIDTH-1:0] rem_n, low_n, quo_n;

    // Quotient fits only if the upper half is below the divisor (covers zero).
    always_comb begin
        too_wide_o = (dividend_i[2*WIDTH-1:WIDTH] >= divisor_i);
    end

    div_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (rem_q),
        .low_i (low_q),
        .quo_i (quo_q),
        .dsr_i (dsr_q),
        .rem_o (rem_n),
        .low_o (low_n),
        .quo_o (quo_n)
    );

    // Load operands, clear on refusal, or advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            low_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load_i) begin
            rem_q <= dividend_i[2*WIDTH-1:WIDTH];
            low_q <= dividend_i[WIDTH-1:0];
            quo_q <= '0;
            dsr_q <= divisor_i;
        end else if (reject_i) begin
            rem_q <= '0;
            low_q <= '0;
            quo_q <= '0;
        end else if (step_i) begin
            rem_q <= rem_n;
            low_q <= low_n;
            quo_q <= quo_n;
        end
    end

    assign quotient_o  = quo_q;
    assign remainder_o = rem_q;

    // R6: a finished run leaves a remainder below the divisor.
    a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !overflow_i) |-> (rem_q < dsr_q));

    // R8: results read zero while overflow is flagged.
    a_r8_zero_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_i |-> (quo_q == '0 && rem_q == '0));
endmodule

// File: rtl/shift_sub_divider.sv
// Module: shift_sub_divider
// Top of the multi-cycle unsigned restoring divider: 2*WIDTH / WIDTH bits,
// one quotient bit per cycle, with a refusal path for quotients too wide.
// Assumes: WIDTH >= 2; operands are held stable in the cycle start_i is high.
module shift_sub_divider #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2*WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0]   divisor_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               overflow_o,
    output logic [WIDTH-1:0]   quotient_o,
    output logic [WIDTH-1:0]   remainder_o
);
    logic too_wide, load, reject, step;

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .too_wide_i (too_wide),
        .load_o     (load),
        .reject_o   (reject),
        .step_o     (step),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .overflow_o (overflow_o)
    );

    div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .load_i      (load),
        .reject_i    (reject),
        .step_i      (step),
        .done_i      (done_o),
        .overflow_i  (overflow_o),
        .too_wide_o  (too_wide),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    // R2: a zero divisor at an accepted start is always refused.
    a_r2_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i == '0) |=> (done_o && overflow_o));
endmodule

// File: tb/shift_sub_divider_bench.sv
// Bench: a behavioural reference model, compared on every falling edge,
// plus directed checks on each division's final result.
module shift_sub_divider_bench;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2*W-1:0] dividend_i = '0;
    logic [W-1:0]   divisor_i = '0;
    logic           busy_o, done_o, overflow_o;
    logic [W-1:0]   quotient_o, remainder_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 1'b0;

    // Reference model state.
    bit m_busy, m_done, m_ovf;
    int m_cnt, m_q, m_r, p_q, p_r;

    always #10 clk = ~clk;

    shift_sub_divider #(.WIDTH(W)) u_shift_sub_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .overflow_o(overflow_o),
        .quotient_o(quotient_o), .remainder_o(remainder_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_ovf <= 0; m_cnt <= 0; m_q <= 0; m_r <= 0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == W - 1) begin
                    m_busy <= 0; m_done <= 1; m_q <= p_q; m_r <= p_r;
                end
            end else if (start_i) begin
                if (int'(dividend_i[2*W-1:W]) >= int'(divisor_i)) begin
                    m_done <= 1; m_ovf <= 1; m_q <= 0; m_r <= 0;
                end else begin
                    m_busy <= 1; m_cnt <= 0; m_ovf <= 0;
                    p_q <= int'(dividend_i) / int'(divisor_i);
                    p_r <= int'(dividend_i) % int'(divisor_i);
                end
            end
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        cycles++;
        if (chk_en) begin
            chk(busy_o == m_busy, "R3", "busy", busy_o, m_busy);
            chk(done_o == m_done, "R4", "done", done_o, m_done);
            chk(overflow_o == m_ovf, "R1", "overflow", overflow_o, m_ovf);
            if (!m_busy) begin
                chk(int'(quotient_o) == m_q, "R5", "quotient", quotient_o, m_q);
                chk(int'(remainder_o) == m_r, "R5", "remainder", remainder_o, m_r);
            end
        end
    end

    // Watchdog.
    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic pulse_start(input logic [2*W-1:0] dd, input logic [W-1:0] dv);
        @(negedge clk);
        start_i = 1'b1; dividend_i = dd; divisor_i = dv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Run one division and check its final outcome directly.
    task automatic run_div(input logic [2*W-1:0] dd, input logic [W-1:0] dv,
                           input string req);
        int eq, er;
        pulse_start(dd, dv);
        if (int'(dd[2*W-1:W]) >= int'(dv)) begin
            chk(done_o && overflow_o && !busy_o, req, "overflow done", overflow_o, 1);
            chk(quotient_o == '0 && remainder_o == '0, "R8", "zeroed result",
                quotient_o, 0);
        end else begin
            chk(busy_o == 1'b1, "R3", "busy after start", busy_o, 1);
            repeat (W) @(negedge clk);
            eq = int'(dd) / int'(dv);
            er = int'(dd) % int'(dv);
            chk(done_o && !busy_o, "R4", "done pulse", done_o, 1);
            chk(int'(quotient_o) == eq, req, "quotient", quotient_o, eq);
            chk(int'(remainder_o) == er, req, "remainder", remainder_o, er);
            chk(remainder_o < dv, "R6", "remainder below divisor", remainder_o, dv);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R4", "done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !overflow_o && quotient_o == '0 &&
            remainder_o == '0, "R9", "reset state", busy_o, 0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        run_div(16'd1000, 8'd7, "R5");
        run_div(16'd0, 8'd3, "R5");
        run_div(16'h00FF, 8'd1, "R5");
        run_div(16'h0500, 8'd5, "R1");          // high half equals divisor
        run_div(16'h0900, 8'd5, "R1");          // high half above divisor
        run_div(16'h0000, 8'd0, "R2");          // zero divisor, zero dividend
        run_div(16'h00AB, 8'd0, "R2");
        // R8: overflow flag holds until the next accepted start
        repeat (3) @(negedge clk);
        chk(overflow_o == 1'b1, "R8", "overflow held", overflow_o, 1);
        run_div(16'hFEFF, 8'd255, "R10");       // carry needed on every step
        run_div(16'h7FFF, 8'd128, "R10");
        run_div(16'h80FF, 8'd129, "R10");
        // R5: results hold while idle
        repeat (4) @(negedge clk);
        chk(int'(quotient_o) == 16'h80FF / 129, "R5", "quotient held",
            quotient_o, 16'h80FF / 129);

        // R7: start during a run is ignored
        pulse_start(16'd5000, 8'd37);
        start_i = 1'b1; dividend_i = 16'd9; divisor_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (W - 1) @(negedge clk);
        chk(done_o == 1'b1, "R7", "done at original time", done_o, 1);
        chk(int'(quotient_o) == 5000 / 37, "R7", "quotient of first run",
            quotient_o, 5000 / 37);
        chk(int'(remainder_o) == 5000 % 37, "R7", "remainder of first run",
            remainder_o, 5000 % 37);
        @(negedge clk);

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] dv;
            logic [2*W-1:0] dd;
            dv = W'($urandom_range(1, 255));
            dd = (2*W)'($urandom_range(0, 65535));
            if (i % 3 != 0) dd[2*W-1:W] = dd[2*W-1:W] % dv;
            run_div(dd, dv, "R5");
        end

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule